// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block sends and receives one SPI frame per start command, acting as the bus master. Each start strobe brings its own set of frame settings. The length code sets the frame size, from 4 to 16 bits. The clock level at rest and the clock edge used for sampling are selectable. The bit order can be MSB first or LSB first. A small selector sets how many system clocks pass between chip select going low and the first clock edge. The engine copies all of these settings at the moment it accepts a start, so changes on the setting inputs during a frame have no effect.

The host drives a transmit word, the settings and a one-cycle start. It then waits for a one-cycle completion pulse, which arrives with the received word. Chip select can be kept low after a frame, so that the next frame follows without releasing the slave. A length code the engine cannot serve is refused: a one-cycle error pulse is raised and no frame starts.

Top module: `spi_frame_master`

## Requirements
- R1: The 4-bit length code gives a frame of code+1 bits, so codes 3 to 15 send 4 to 16 bits. The frame has exactly 2×(code+1) clock edges. The received word is right-justified, with all bits above the frame cleared.
- R2: Length codes 0, 1 and 2 are refused. `cfg_err` pulses for one cycle, `cs_n` stays high and no `done` is given.
- R3: The resting level of `sck` equals `cpol`: 0 rests low and 1 rests high. After the last edge of a frame, `sck` is back at that level.
- R4: With `cpha`=0, data is sampled on the leading edge and changed on the trailing edge. The first bit is already on `mosi` in the cycle `cs_n` falls.
- R5: With `cpha`=1, data is changed on the leading edge and sampled on the trailing edge.
- R6: `lsb_first`=0 sends and receives MSB first, and `lsb_first`=1 does so LSB first. Both directions use the same order.
- R7: `lead_sel` values 0, 1, 2 and 3 put 1, 3, 5 and 7 system clocks between the fall of `cs_n` and the first `sck` edge.
- R8: Every `sck` half period inside a frame lasts `HALF_CYC` system clocks.
- R9: Settings are captured when a start is accepted. Changing the setting inputs, or pulsing `start`, while `busy` is high does not affect the running frame.
- R10: A frame ends with `done` high for exactly one cycle and `rx_data` valid. In that same cycle `cs_n` returns high, unless `hold_cs` was set at the start. If it was set, `cs_n` stays low until a later frame ends without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle frame request |
| tx_data | input | DATA_W | Word to send, right-justified |
| frm_code | input | 4 | Frame length minus one |
| cpol | input | 1 | Clock resting level |
| cpha | input | 1 | Sampling edge select |
| lsb_first | input | 1 | Bit order select |
| lead_sel | input | 2 | Chip-select-to-clock delay select |
| hold_cs | input | 1 | Keep chip select low after the frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | One-cycle pulse for a refused length code |
| rx_data | output | DATA_W | Received word, right-justified |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A bench slave model follows the selected polarity, phase, length and order. Frames cover all four clock modes, both bit orders, lengths of 4, 6, 8, 10, 12 and 16 bits, and every delay code. The words chosen are asymmetric, so reversed order, a wrong sampling edge or a missing bit each yield a different mismatch. A frame with scrambled setting inputs and an extra start after acceptance separates latched settings from live ones. A chained pair of frames with chip select held separates continuous selection from normal release, and the refused codes show that a bad length starts nothing.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

   localparam int CODE_W = 4;
   localparam int DLY_W  = 2;

   // settings captured when a frame is accepted
   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              cpol;
      logic              cpha;
      logic              lsb_first;
      logic              keep;
   } spi_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_END
   } spi_state_e;

endpackage

// File: rtl/spi_fm_pace.sv
module spi_fm_pace #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             en,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (reload)            cnt_q <= reload_val;
      else if (en && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
   import spi_fm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALF_CYC = 2,
   parameter int MIN_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  spi_cfg_t          cfg_in,
   input  logic [DLY_W-1:0]  dly_in,
   output logic              busy,
   output logic              done,
   output logic              cfg_err,
   output logic              sck,
   output logic              cs_n,
   output logic              ld,
   output logic              drv,
   output logic [CODE_W-1:0] drv_idx,
   output logic              cap,
   output logic [CODE_W-1:0] cap_idx,
   output logic [CODE_W-1:0] run_code,
   output logic              run_lsb
);

   localparam int EDGE_W   = CODE_W + 2;
   localparam int LEAD_MAX = 2 ** (DLY_W + 1);
   localparam int PACE_MAX = (HALF_CYC > LEAD_MAX) ? HALF_CYC : LEAD_MAX;
   localparam int PACE_W   = $clog2(PACE_MAX + 1);

   spi_state_e        st_q;
   spi_cfg_t          cfg_q;
   logic [EDGE_W-1:0] edge_q, edge_nx, last_edge;
   logic [CODE_W-1:0] bidx_q;
   logic              code_ok, reject, tick, lead_edge, pace_zero, in_run;
   logic [PACE_W-1:0] pace_val;

   assign code_ok   = (cfg_in.code >= CODE_W'(MIN_CODE)) && (cfg_in.code <= CODE_W'(DATA_W - 1));
   assign ld        = start && (st_q == ST_IDLE) && code_ok;
   assign reject    = start && (st_q == ST_IDLE) && !code_ok;
   assign in_run    = (st_q == ST_LEAD) || (st_q == ST_XFER);
   assign tick      = pace_zero && in_run;
   assign edge_nx   = edge_q + EDGE_W'(1);
   assign lead_edge = edge_nx[0];
   assign last_edge = {1'b0, cfg_q.code, 1'b0} + EDGE_W'(2);
   assign pace_val  = ld ? PACE_W'({dly_in, 1'b0}) : PACE_W'(HALF_CYC - 1);

   spi_fm_pace #(.CNT_W(PACE_W)) u_pace (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (ld || tick),
      .reload_val (pace_val),
      .en         (in_run),
      .zero       (pace_zero)
   );

   // edge actions: the sampling edge depends on phase, the change edge is the other one
   assign cap     = tick && (cfg_q.cpha ? !lead_edge : lead_edge);
   assign cap_idx = bidx_q;
   assign drv     = tick && (cfg_q.cpha ? lead_edge : (!lead_edge && edge_nx != last_edge));
   assign drv_idx = cfg_q.cpha ? bidx_q : bidx_q + CODE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cfg_q   <= '0;
         edge_q  <= '0;
         bidx_q  <= '0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         done    <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         done    <= 1'b0;
         cfg_err <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (ld) begin
                  cfg_q  <= cfg_in;
                  cs_n   <= 1'b0;
                  sck    <= cfg_in.cpol;
                  edge_q <= '0;
                  bidx_q <= '0;
                  st_q   <= ST_LEAD;
               end else begin
                  cfg_err <= reject;
                  if (cs_n) sck <= cfg_in.cpol;
               end
            end
            ST_LEAD, ST_XFER: begin
               if (tick) begin
                  sck    <= ~sck;
                  edge_q <= edge_nx;
                  if (!lead_edge) bidx_q <= bidx_q + CODE_W'(1);
                  st_q   <= (edge_nx == last_edge) ? ST_END : ST_XFER;
               end
            end
            ST_END: begin
               sck  <= cfg_q.cpol;
               done <= 1'b1;
               cs_n <= ~cfg_q.keep;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign run_code = cfg_q.code;
   assign run_lsb  = cfg_q.lsb_first;

endmodule

// File: rtl/spi_fm_data.sv
module spi_fm_data
   import spi_fm_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [DATA_W-1:0] tx_in,
   input  logic [CODE_W-1:0] ld_code,
   input  logic              ld_lsb,
   input  logic              ld_cpha,
   input  logic [CODE_W-1:0] run_code,
   input  logic              run_lsb,
   input  logic              drv,
   input  logic [CODE_W-1:0] drv_idx,
   input  logic              cap,
   input  logic [CODE_W-1:0] cap_idx,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx
);

   // serial slot -> word bit position, for either order
   function automatic logic [CODE_W-1:0] slot_pos(input logic [CODE_W-1:0] idx,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic              lsb);
      return lsb ? idx : code - idx;
   endfunction

   logic [DATA_W-1:0] tx_q;
   logic [CODE_W-1:0] cap_pos;

   assign cap_pos = slot_pos(cap_idx, run_code, run_lsb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         mosi <= 1'b0;
      end else if (ld) begin
         tx_q <= tx_in;
         mosi <= ld_cpha ? 1'b0 : tx_in[slot_pos('0, ld_code, ld_lsb)];
      end else if (drv) begin
         mosi <= tx_q[slot_pos(drv_idx, run_code, run_lsb)];
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_rx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              rx[i] <= 1'b0;
         else if (ld)                             rx[i] <= 1'b0;
         else if (cap && cap_pos == CODE_W'(i))   rx[i] <= miso;
      end
   end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
   import spi_fm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALF_CYC = 2,
   parameter int MIN_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [3:0]        frm_code,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic [1:0]        lead_sel,
   input  logic              hold_cs,
   output logic              busy,
   output logic              done,
   output logic              cfg_err,
   output logic [DATA_W-1:0] rx_data,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);

   initial begin
      assert (DATA_W >= 4 && DATA_W <= 2 ** CODE_W) else $error("DATA_W out of range");
      assert (HALF_CYC >= 1) else $error("HALF_CYC must be at least 1");
      assert (MIN_CODE >= 1 && MIN_CODE < DATA_W) else $error("MIN_CODE out of range");
   end

   spi_cfg_t          cfg_in;
   logic              ld, drv, cap, run_lsb;
   logic [CODE_W-1:0] drv_idx, cap_idx, run_code;

   assign cfg_in = '{code: frm_code, cpol: cpol, cpha: cpha,
                     lsb_first: lsb_first, keep: hold_cs};

   spi_fm_ctrl #(
      .DATA_W   (DATA_W),
      .HALF_CYC (HALF_CYC),
      .MIN_CODE (MIN_CODE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cfg_in   (cfg_in),
      .dly_in   (lead_sel),
      .busy     (busy),
      .done     (done),
      .cfg_err  (cfg_err),
      .sck      (sck),
      .cs_n     (cs_n),
      .ld       (ld),
      .drv      (drv),
      .drv_idx  (drv_idx),
      .cap      (cap),
      .cap_idx  (cap_idx),
      .run_code (run_code),
      .run_lsb  (run_lsb)
   );

   spi_fm_data #(.DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld),
      .tx_in    (tx_data),
      .ld_code  (frm_code),
      .ld_lsb   (lsb_first),
      .ld_cpha  (cpha),
      .run_code (run_code),
      .run_lsb  (run_lsb),
      .drv      (drv),
      .drv_idx  (drv_idx),
      .cap      (cap),
      .cap_idx  (cap_idx),
      .miso     (miso),
      .mosi     (mosi),
      .rx       (rx_data)
   );

endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker #(
   parameter int DATA_W   = 16,
   parameter int MIN_CODE = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [3:0] frm_code,
   input logic       busy,
   input logic       done,
   input logic       cfg_err,
   input logic       sck,
   input logic       cs_n
);

   // R2: an error pulse only follows an idle start with an unusable code
   p_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(start) && !$past(busy) &&
                  ($past(frm_code) < 4'(MIN_CODE) || $past(frm_code) > 4'(DATA_W - 1)));

   // R2: a refused request never leaves a frame running
   p_err_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy);

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: chip select is low for the whole frame
   p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);

   // R3: the clock is already at rest when completion is signalled
   p_done_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $stable(sck));

   // R9: a start during a frame does not abort it
   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !$past(busy) |=> busy);

endmodule

bind spi_frame_master spi_fm_checker #(
   .DATA_W   (DATA_W),
   .MIN_CODE (MIN_CODE)
) u_spi_fm_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .frm_code (frm_code),
   .busy     (busy),
   .done     (done),
   .cfg_err  (cfg_err),
   .sck      (sck),
   .cs_n     (cs_n)
);

// File: tb/test_spi_frame_master.sv
`timescale 1ns/1ps
module test_spi_frame_master;

   localparam int DATA_W   = 16;
   localparam int HALF_CYC = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [DATA_W-1:0] tx_data = '0;
   logic [3:0]        frm_code = 4'd7;
   logic              cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, hold_cs = 1'b0;
   logic [1:0]        lead_sel = 2'd0;
   logic              miso = 1'b0;
   logic              busy, done, cfg_err, sck, cs_n, mosi;
   logic [DATA_W-1:0] rx_data;

   always #5 clk = ~clk;

   spi_frame_master #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .MIN_CODE(3)) i_spi_frame_master (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .frm_code(frm_code),
      .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .lead_sel(lead_sel), .hold_cs(hold_cs),
      .busy(busy), .done(done), .cfg_err(cfg_err), .rx_data(rx_data),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

   int n_chk = 0, n_bad = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // settings of the frame in flight, as the bench believes them
   int                cur_n = 8, cur_dly = 0;
   logic              cur_lsb = 0, cur_cpha = 0, cur_cpol = 0;
   logic [DATA_W-1:0] cur_tx = '0, s_tx = '0, s_rx = '0;
   int                s_edge = 0;

   function automatic int posn(input int k);
      return cur_lsb ? k : cur_n - 1 - k;
   endfunction

   // slave model: follows the mode definitions in R4/R5/R6
   always @(sck) begin
      if (rst_n && !cs_n) begin
         s_edge++;
         if (s_edge <= 2 * cur_n) begin
            if (!cur_cpha) begin
               if (s_edge % 2 == 1) s_rx[posn((s_edge - 1) / 2)] = mosi;
               else if (s_edge / 2 < cur_n) miso = s_tx[posn(s_edge / 2)];
            end else begin
               if (s_edge % 2 == 1) miso = s_tx[posn((s_edge - 1) / 2)];
               else s_rx[posn(s_edge / 2 - 1)] = mosi;
            end
         end
      end
   end

   typedef struct {
      logic [DATA_W-1:0] rx;
      logic [DATA_W-1:0] mo;
      int                n;
      logic              cpol;
      logic              keep;
      string             tag;
   } exp_t;
   exp_t sb_q[$];

   // monitor: timing of cs/sck and scoreboard compare at done
   int   ncyc = 0, t_cs = 0, t_last = 0, hp_bad = 0;
   bit   cs_fell = 0, seen_first = 0;
   logic prev_cs = 1, prev_sck = 0, prev_done = 0;

   always @(negedge clk) begin
      ncyc++;
      if (rst_n) begin
         if (prev_cs && !cs_n) begin
            cs_fell = 1;
            t_cs    = ncyc;
            if (!cur_cpha)
               check(mosi == cur_tx[posn(0)], "R4 first bit before first edge", mosi, cur_tx[posn(0)]);
         end
         if (!cs_n && sck !== prev_sck) begin
            if (!seen_first) begin
               seen_first = 1;
               if (cs_fell)
                  check(ncyc - t_cs == 2 * cur_dly + 1, "R7 cs-to-clock delay", ncyc - t_cs, 2 * cur_dly + 1);
            end else if (ncyc - t_last != HALF_CYC) begin
               hp_bad++;
            end
            t_last = ncyc;
         end
         if (prev_done && done) check(0, "R10 done wider than one cycle", 1, 0);
         if (done) begin
            check(hp_bad == 0, "R8 half period length", hp_bad, 0);
            hp_bad = 0; seen_first = 0; cs_fell = 0;
            if (sb_q.size() == 0) begin
               check(0, "R10 done without request", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(rx_data == e.rx, {e.tag, " received word"}, rx_data, e.rx);
               check(s_rx == e.mo, {e.tag, " word seen by slave"}, s_rx, e.mo);
               check(s_edge == 2 * e.n, "R1 clock edge count", s_edge, 2 * e.n);
               check(sck == e.cpol, "R3 clock at rest after frame", sck, e.cpol);
               check(cs_n == !e.keep, "R10 chip select after frame", cs_n, !e.keep);
            end
         end
      end
      prev_cs = cs_n; prev_sck = sck; prev_done = done;
   end

   task automatic run_frame(input logic [3:0] code, input logic cp, input logic ph, input logic lsb,
                            input logic [1:0] dly, input logic keep, input logic [DATA_W-1:0] tx,
                            input logic [DATA_W-1:0] stx, input bit poke, input string tag);
      logic [DATA_W-1:0] mask;
      exp_t e;
      int w;
      @(negedge clk);
      frm_code = code; cpol = cp; cpha = ph; lsb_first = lsb; lead_sel = dly;
      hold_cs = keep; tx_data = tx;
      cur_n = int'(code) + 1; cur_lsb = lsb; cur_cpha = ph; cur_cpol = cp; cur_dly = int'(dly);
      cur_tx = tx; s_tx = stx; s_rx = '0; s_edge = 0;
      mask = (cur_n == DATA_W) ? '1 : DATA_W'((32'd1 << cur_n) - 1);
      e.rx = stx & mask; e.mo = tx & mask; e.n = cur_n; e.cpol = cp; e.keep = keep; e.tag = tag;
      sb_q.push_back(e);
      if (!ph) miso = stx[posn(0)];
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R9: scramble every setting input while the frame runs
      cpol = ~cp; cpha = ~ph; lsb_first = ~lsb; lead_sel = ~dly; hold_cs = ~keep;
      frm_code = 4'd4; tx_data = ~tx;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      w = 0;
      while (!done && w < 3000) begin @(negedge clk); w++; end
      if (w >= 3000) check(0, "R10 done timeout", 0, 1);
      @(negedge clk);
      cpol = cp; cpha = ph; lsb_first = lsb; lead_sel = dly; hold_cs = keep; frm_code = code;
   endtask

   task automatic try_reserved(input logic [3:0] code);
      int ec = 0, cs_low = 0, dn = 0;
      @(negedge clk); frm_code = code;
      @(negedge clk); start = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); start = 1'b0;
         if (cfg_err) ec++;
         if (!cs_n) cs_low++;
         if (done) dn++;
      end
      check(ec == 1, "R2 error pulse count", ec, 1);
      check(cs_low == 0 && dn == 0, "R2 no frame started", cs_low + dn, 0);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1, "R10 reset chip select", cs_n, 1);
      check(done == 1'b0 && busy == 1'b0 && cfg_err == 1'b0, "R10 reset flags", {done, busy, cfg_err}, 0);
      check(sck == 1'b0, "R3 reset clock level", sck, 0);
      @(negedge clk);
      cpol = 1'b1;
      repeat (2) @(negedge clk);
      check(sck == 1'b1, "R3 idle clock follows polarity", sck, 1);
      cpol = 1'b0;

      run_frame(4'd7,  0, 0, 0, 2'd0, 0, 16'h00A5, 16'h003C, 0, "R4 R6 mode0 msb 8b");
      run_frame(4'd15, 1, 1, 1, 2'd3, 0, 16'h8E31, 16'h1F4C, 0, "R5 R6 mode3 lsb 16b");
      run_frame(4'd3,  0, 1, 0, 2'd1, 0, 16'h000B, 16'hFFF6, 0, "R1 R5 mode1 4b");
      run_frame(4'd11, 1, 0, 1, 2'd2, 0, 16'h0A53, 16'h0C96, 1, "R9 R4 mode2 lsb 12b");
      try_reserved(4'd2);
      try_reserved(4'd0);
      run_frame(4'd9,  0, 0, 0, 2'd1, 1, 16'h02D3, 16'h0171, 0, "R10 held cs first");
      check(cs_n == 1'b0, "R10 cs held between frames", cs_n, 0);
      run_frame(4'd9,  0, 1, 1, 2'd0, 1, 16'h0349, 16'h0266, 0, "R10 held cs second");
      run_frame(4'd5,  0, 0, 1, 2'd2, 0, 16'h002D, 16'h0013, 0, "R10 R6 release frame");
      run_frame(4'd15, 0, 0, 0, 2'd3, 0, 16'hC3A1, 16'h5E0F, 0, "R1 R4 msb 16b");
      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R10 all frames completed", sb_q.size(), 0);
      check(cs_n == 1'b1, "R10 cs released at end", cs_n, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule